// File: doc/BRIEF.md
# Segmented Instruction Address Unit

This block keeps the segment state and the instruction pointer of a processor core that uses segmented addressing. It holds four 16-bit segment registers: code, data, stack and extra. It also holds a 16-bit instruction pointer. A 20-bit physical address is made by moving a segment value up four bit places and adding a 16-bit offset. The sum wraps within the 1 MB space.

The fetch side always sees the address formed from the code segment and the pointer. The unit raises a valid flag toward the fetch side. When that side accepts a fetch in a given cycle, it reports the length of the fetched instruction, and the pointer moves forward by that length. Two kinds of jump can redirect the fetch. A far jump replaces both the code segment and the pointer. A register jump replaces only the pointer.

The ordinary move path can load the data, stack and extra segment registers. It can never reach the code segment or the pointer. A separate combinational port turns any segment register plus a caller-supplied offset into a physical address for data accesses.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the code segment is FFFFh and the pointer is 0000h, so the fetch address is FFFF0h. The data, stack and extra segments are 0000h. `fetch_valid` is low during reset and high from the first clock edge after reset is released.
- R2: Every physical address equals (segment × 16 + offset) mod 2^20. For example, 1230h:00C8h gives 123C8h, and FFFFh:0010h gives 00000h.
- R3: `fetch_addr` is the physical address of the current code segment and pointer, in the same cycle.
- R4: A fetch is accepted in a cycle where `fetch_valid` and `fetch_ready` are both high. After the next clock edge the pointer has grown by `fetch_len`. Without that handshake, and without a jump, the pointer holds its value.
- R5: The pointer advance wraps modulo 2^16, and the code segment does not change when it wraps.
- R6: When `jmp_far` is high, the next clock edge loads the code segment from `jmp_seg` and the pointer from `jmp_off`. Jumping to 2AE3h:0003h gives the fetch address 2AE33h.
- R7: When `jmp_reg` is high and `jmp_far` is low, the next clock edge loads the pointer from `jmp_reg_val` and leaves the code segment unchanged.
- R8: A far jump takes precedence over a register jump. Either kind of jump takes precedence over a fetch advance requested in the same cycle.
- R9: When `seg_wr_en` is high, the next clock edge loads `seg_wr_data` into the segment selected by `seg_wr_sel`. The select codes are 0 for code, 1 for data, 2 for stack and 3 for extra. A write that selects code (0) changes nothing.
- R10: `data_addr` is the physical address of the segment selected by `data_seg_sel` (same codes as R9) plus `data_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 20 | Physical fetch address (code segment : pointer) |
| fetch_valid | output | 1 | Fetch address offered to the fetch side |
| fetch_ready | input | 1 | Fetch side accepts the offered address |
| fetch_len | input | 4 | Length in bytes of the fetched instruction |
| jmp_far | input | 1 | Load code segment and pointer |
| jmp_seg | input | 16 | Segment for a far jump |
| jmp_off | input | 16 | Offset for a far jump |
| jmp_reg | input | 1 | Load pointer only |
| jmp_reg_val | input | 16 | Register value for a register jump |
| seg_wr_en | input | 1 | Ordinary segment move enable |
| seg_wr_sel | input | 2 | Segment selected for the move |
| seg_wr_data | input | 16 | Value for the move |
| data_seg_sel | input | 2 | Segment used for the data address |
| data_off | input | 16 | Offset of the data access |
| data_addr | output | 20 | Physical data address |

## Verification
Some behaviours are checked by assertions on every cycle. These are:
- a pointer advance by exactly the accepted length;
- the pointer holding when nothing acts on it;
- the code segment being shielded from the move path;
- the far-jump load;
- the low nibble of every formed address passing straight through from the offset;
- the valid flag staying high once raised.

Other behaviours can only be shown by the bench's scenarios, which compare the ports against a separate reference model. These are:
- the exact reset address;
- the two worked address examples;
- 20-bit wrap-around;
- pointer wrap that leaves the code segment alone;
- jump precedence when several commands collide in one cycle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int PA_W   = SEG_W + SHIFT;
  localparam int NUM_SEG = 4;
  localparam int SEL_W  = $clog2(NUM_SEG);

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_sel_e;

  // base (segment moved up SHIFT places) plus offset, carry out of the top dropped
  function automatic logic [PA_W-1:0] form_phys(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ext_off;
    base    = {seg, {SHIFT{1'b0}}};
    ext_off = {{(PA_W-OFF_W){1'b0}}, off};
    return base + ext_off;
  endfunction

  function automatic logic [OFF_W-1:0] bump_ptr(input logic [OFF_W-1:0] ptr,
                                                input logic [OFF_W-1:0] len);
    return ptr + len;
  endfunction
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys
);
  assign phys = form_phys(seg, off);

  // R2: offset low bits pass through untouched by the shifted segment
  always_comb begin
    p_low_nibble_r2: assert (phys[SHIFT-1:0] == off[SHIFT-1:0]);
  end
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mv_en,
  input  seg_sel_e         mv_sel,
  input  logic [SEG_W-1:0] mv_data,
  input  logic             far_load,
  input  logic [SEG_W-1:0] far_seg,
  input  seg_sel_e         rd_sel,
  output logic [SEG_W-1:0] rd_seg,
  output logic [SEG_W-1:0] cs_out
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];

  // move aimed at the code segment: observed event, never acted upon
  logic move_blocked;
  assign move_blocked = mv_en && (mv_sel == SEG_CODE);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_V = (g == int'(SEG_CODE)) ? RESET_CS : '0;
    logic             load;
    logic [SEG_W-1:0] load_val;
    if (g == int'(SEG_CODE)) begin : g_code
      assign load     = far_load;
      assign load_val = far_seg;
    end else begin : g_gen
      assign load     = mv_en && (mv_sel == seg_sel_e'(g));
      assign load_val = mv_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    seg_q[g] <= RST_V;
      else if (load) seg_q[g] <= load_val;
    end
  end

  assign rd_seg = seg_q[rd_sel];
  assign cs_out = seg_q[SEG_CODE];

  // R9: the move path never alters the code segment
  p_cs_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (move_blocked && !far_load) |=> $stable(cs_out));
  // R6: far jump lands the given segment
  p_far_seg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    far_load |=> (cs_out == $past(far_seg)));
endmodule

// File: rtl/seg_ip_unit.sv
module seg_ip_unit
  import seg_addr_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LEN_W-1:0] len,
  input  logic             far_load,
  input  logic [OFF_W-1:0] far_off,
  input  logic             reg_load,
  input  logic [OFF_W-1:0] reg_val,
  output logic [OFF_W-1:0] ip
);
  logic [OFF_W-1:0] ip_q;
  logic             step_taken;
  logic             any_jump;
  logic [OFF_W-1:0] len_ext;

  assign any_jump   = far_load || reg_load;
  assign step_taken = adv && !any_jump;
  assign len_ext    = {{(OFF_W-LEN_W){1'b0}}, len};

  always_ff @(posedge clk) begin
    if (!rst_n)          ip_q <= '0;
    else if (far_load)   ip_q <= far_off;
    else if (reg_load)   ip_q <= reg_val;
    else if (adv)        ip_q <= bump_ptr(ip_q, len_ext);
  end

  assign ip = ip_q;

  // R4: accepted fetch moves the pointer by the reported length
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> (ip == OFF_W'($past(ip) + $past(len_ext))));
  // R4: idle pointer holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !any_jump) |=> $stable(ip));
  // R8: register jump wins over advance when no far jump
  p_reg_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_load && !far_load) |=> (ip == $past(reg_val)));
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int               LEN_W    = 4,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [19:0]      fetch_addr,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  input  logic [LEN_W-1:0] fetch_len,
  input  logic             jmp_far,
  input  logic [15:0]      jmp_seg,
  input  logic [15:0]      jmp_off,
  input  logic             jmp_reg,
  input  logic [15:0]      jmp_reg_val,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [15:0]      seg_wr_data,
  input  logic [1:0]       data_seg_sel,
  input  logic [15:0]      data_off,
  output logic [19:0]      data_addr
);
  logic             valid_q;
  logic             fetch_fire;
  logic [SEG_W-1:0] cs;
  logic [SEG_W-1:0] data_seg;
  logic [OFF_W-1:0] ip;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign fetch_valid = valid_q;
  assign fetch_fire  = valid_q && fetch_ready;

  seg_regfile #(.RESET_CS(RESET_CS)) u_segs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_en    (seg_wr_en),
    .mv_sel   (seg_sel_e'(seg_wr_sel)),
    .mv_data  (seg_wr_data),
    .far_load (jmp_far),
    .far_seg  (jmp_seg),
    .rd_sel   (seg_sel_e'(data_seg_sel)),
    .rd_seg   (data_seg),
    .cs_out   (cs)
  );

  seg_ip_unit #(.LEN_W(LEN_W)) u_ip (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (fetch_fire),
    .len      (fetch_len),
    .far_load (jmp_far),
    .far_off  (jmp_off),
    .reg_load (jmp_reg),
    .reg_val  (jmp_reg_val),
    .ip       (ip)
  );

  seg_addr_gen u_fetch_ag (.seg(cs),       .off(ip),       .phys(fetch_addr));
  seg_addr_gen u_data_ag  (.seg(data_seg), .off(data_off), .phys(data_addr));

  // R4: once offered, the fetch address stays offered
  p_valid_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> fetch_valid);
  // R5: pointer advance alone never touches the code segment
  p_cs_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fire && !jmp_far) |=> $stable(cs));
endmodule

// File: tb/seg_addr_unit_tb_top.sv
module seg_addr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] fetch_addr;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [3:0]  fetch_len = '0;
  logic        jmp_far = 1'b0;
  logic [15:0] jmp_seg = '0;
  logic [15:0] jmp_off = '0;
  logic        jmp_reg = 1'b0;
  logic [15:0] jmp_reg_val = '0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [1:0]  data_seg_sel = '0;
  logic [15:0] data_off = '0;
  logic [19:0] data_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference state
  int unsigned m_seg [4];
  int unsigned m_ip;
  bit          m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_len(fetch_len),
    .jmp_far(jmp_far), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
    .jmp_reg(jmp_reg), .jmp_reg_val(jmp_reg_val),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .data_seg_sel(data_seg_sel), .data_off(data_off), .data_addr(data_addr)
  );

  function automatic int unsigned ref_phys(int unsigned s, int unsigned o);
    return (s * 16 + o) % (1 << 20);
  endfunction

  task automatic chk(input string tag, input int unsigned got, input int unsigned exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
    m_ip = 0; m_valid = 0;
  endtask

  task automatic model_clock();
    if (jmp_far) begin
      m_seg[0] = jmp_seg; m_ip = jmp_off;
    end else if (jmp_reg) begin
      m_ip = jmp_reg_val;
    end else if (m_valid && fetch_ready) begin
      m_ip = (m_ip + fetch_len) % 65536;
    end
    if (seg_wr_en && seg_wr_sel != 2'd0) m_seg[seg_wr_sel] = seg_wr_data;
    m_valid = 1;
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic quiet();
    fetch_ready = 0; jmp_far = 0; jmp_reg = 0; seg_wr_en = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5E6A_1DD1));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    data_seg_sel = 2'd1; data_off = 16'h0000;
    #1;
    chk("R1 fetch_addr in reset", fetch_addr, 20'hFFFF0);
    chk("R1 data seg in reset", data_addr, 20'h00000);
    chk("R1 valid low in reset", fetch_valid, 0);
    rst_n = 1'b1;
    step();
    chk("R1 fetch_addr after reset", fetch_addr, 20'hFFFF0);
    chk("R1 valid after reset", fetch_valid, 1);

    // R9/R2/R10: data segment load and 1230:00C8
    seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'h1230;
    step(); quiet();
    data_seg_sel = 2'd1; data_off = 16'h00C8; #1;
    chk("R2 1230:00C8", data_addr, 20'h123C8);

    // R6: far jump example
    jmp_far = 1; jmp_seg = 16'h2AE3; jmp_off = 16'h0003;
    step(); quiet(); #1;
    chk("R6 far jump 2AE3:0003", fetch_addr, 20'h2AE33);

    // R4: accepted fetch then idle
    fetch_ready = 1; fetch_len = 4'd5;
    step(); quiet(); #1;
    chk("R4 advance by 5", fetch_addr, 20'h2AE38);
    step(); #1;
    chk("R4 hold without ready", fetch_addr, 20'h2AE38);

    // R9: move aimed at code segment ignored
    seg_wr_en = 1; seg_wr_sel = 2'd0; seg_wr_data = 16'h1234;
    step(); quiet();
    data_seg_sel = 2'd0; data_off = 16'h0000; #1;
    chk("R9 code fetch unchanged", fetch_addr, 20'h2AE38);
    chk("R9 code segment unchanged", data_addr, 20'h2AE30);

    // R7: register jump keeps code segment
    jmp_reg = 1; jmp_reg_val = 16'h0100;
    step(); quiet(); #1;
    chk("R7 register jump", fetch_addr, 20'h2AF30);

    // R8: far beats register and advance
    jmp_far = 1; jmp_seg = 16'h1000; jmp_off = 16'hFFFE;
    jmp_reg = 1; jmp_reg_val = 16'h0005; fetch_ready = 1; fetch_len = 4'd7;
    step(); quiet(); #1;
    chk("R8 far wins", fetch_addr, 20'h1FFFE);

    // R5: pointer wrap keeps segment
    fetch_ready = 1; fetch_len = 4'd3;
    step(); quiet(); #1;
    chk("R5 pointer wrap", fetch_addr, 20'h10001);

    // R2: 20-bit wrap
    seg_wr_en = 1; seg_wr_sel = 2'd3; seg_wr_data = 16'hFFFF;
    step(); quiet();
    data_seg_sel = 2'd3; data_off = 16'h0010; #1;
    chk("R2 wrap FFFF:0010", data_addr, 20'h00000);

    // R8: register jump beats advance
    jmp_reg = 1; jmp_reg_val = 16'h0040; fetch_ready = 1; fetch_len = 4'd2;
    step(); quiet(); #1;
    chk("R8 reg beats advance", fetch_addr, 20'h10040);

    // R3/R10: random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      fetch_ready  = ($urandom % 4) != 0;
      fetch_len    = 4'($urandom % 16);
      jmp_far      = ($urandom % 20) == 0;
      jmp_seg      = 16'($urandom);
      jmp_off      = 16'($urandom);
      jmp_reg      = ($urandom % 16) == 0;
      jmp_reg_val  = 16'($urandom);
      seg_wr_en    = ($urandom % 4) == 0;
      seg_wr_sel   = 2'($urandom);
      seg_wr_data  = 16'($urandom);
      data_seg_sel = 2'($urandom);
      data_off     = 16'($urandom);
      #1;
      chk("R3 fetch address", fetch_addr, ref_phys(m_seg[0], m_ip));
      chk("R10 data address", data_addr, ref_phys(m_seg[data_seg_sel], data_off));
      step();
    end
    finish_run();
  end
endmodule